// File: doc/BRIEF.md
# Dual-Mode Modular Lane Array

This block is a small programmable datapath that lets one set of arithmetic lanes serve two public-key schemes. It holds an eight-entry register file whose entries are vectors of twenty 11-bit lane words. A host fills the register file through a write port and reads results back through a combinational read port. It then issues a command that names a mode, a base register, a destination register and, for the lattice mode, a ternary sign pattern.

A controller steps through load, execute and writeback phases. During load it copies the operand registers, one per cycle, into per-operand latches. During execute every lane computes its result in parallel. During writeback the result vector goes into the destination register. In mode 0 each lane computes a multiply-accumulate over the field of 31 elements, as used by the multivariate signature scheme. In mode 1 each lane sums six signed or dropped terms modulo 2048, as used by the lattice encryption scheme. The same lane hardware serves both modes, and the mode selects which arithmetic path feeds the result.

Top module: `dual_lane_array`

## Requirements
- R1: After reset `busy` and `done` are 0 and every register file entry reads as zero on `rd_data`.
- R2: While the block is idle, a write with `wr_en` high stores `wr_data` into entry `wr_addr`. `rd_data` shows entry `rd_addr` combinationally, so the new value is visible from the cycle after the write edge.
- R3: In mode 0 (`cmd_mode`=0), each lane i takes the low 5 bits of lane i from entries base, base+1 and base+2 as a, b and c. A 5-bit value of 31 counts as 0. The lane writes ((a·b)+c) mod 31, zero-extended to 11 bits, into lane i of the destination. The upper 6 bits of each operand have no effect.
- R4: In mode 1 (`cmd_mode`=1), each lane i writes into lane i of the destination the sum over k=0..5 of t_k mod 2048. Here x_k is lane i of entry base+k, and t_k is selected by `cmd_tern[2k+1:2k]`: 2'b01 gives +x_k, 2'b11 gives −x_k, and 2'b00 or 2'b10 gives 0.
- R5: When `start` is sampled high while idle, `busy` is high from the next cycle for N+2 cycles, where N is 3 in mode 0 and 6 in mode 1. `done` is high only in the last of those cycles, and the destination reads the new result in the cycle after `done`.
- R6: While busy, `start` and the command inputs have no effect. The mode, operands, timing and result of the running command are unchanged.
- R7: While busy, host writes are discarded.
- R8: Operand register addresses wrap modulo 8, so base+k selects entry (base+k) mod 8.
- R9: A command's result depends only on its own operands and controls, not on the mode or data of earlier commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write enable |
| wr_addr | input | 3 | Host write entry |
| wr_data | input | 220 | Host write vector, lane i at bits [11i+10:11i] |
| rd_addr | input | 3 | Host read entry |
| rd_data | output | 220 | Contents of entry rd_addr |
| start | input | 1 | Command request |
| cmd_mode | input | 1 | 0 for mod-31 multiply-add, 1 for six-term mod-2048 sum |
| cmd_base | input | 3 | First operand entry |
| cmd_dst | input | 3 | Destination entry |
| cmd_tern | input | 12 | Two-bit sign code per term (mode 1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final (writeback) cycle of a command |

## Verification
The assertions take for granted that `start` is raised only as a one-cycle request, and that the host does not rely on writes during a command. They check that a request while busy never restarts the sequence and never changes the latched mode, that `done` is a single cycle ending the busy window, and that mode 0 results always fall below 31. The stimulus pulses `start` for one cycle per command. It deliberately raises `start` with a different mode, along with a host write, in the middle of a command, so that the ignore paths are exercised and their effect is checked through the result and a later read.

// File: rtl/dla_pkg.sv
package dla_pkg;
  parameter int LANES = 20;
  parameter int OPW   = 11;
  parameter int NREG  = 8;
  parameter int NOPS  = 6;
  localparam int VW   = LANES * OPW;
  localparam int AW   = $clog2(NREG);
  localparam int CW   = $clog2(NOPS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } dla_state_e;
endpackage

// File: rtl/dla_regfile.sv
module dla_regfile
  import dla_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [VW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [VW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [VW-1:0] rdata_b
);
  logic [VW-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        mem_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/dla_lane.sv
module dla_lane
  import dla_pkg::*;
(
  input  logic                      mode,
  input  logic [NOPS-1:0][OPW-1:0]  ops,
  input  logic [2*NOPS-1:0]         tern,
  output logic [OPW-1:0]            res
);
  localparam int SW = 5;
  localparam logic [SW-1:0] P = 5'd31;

  logic [SW-1:0]  a_r, b_r, c_r;
  logic [10:0]    mac;
  logic [10:0]    red;
  logic [OPW-1:0] sum;

  function automatic logic [SW-1:0] fold(input logic [SW-1:0] v);
    return (v == P) ? '0 : v;
  endfunction

  always_comb begin
    a_r = fold(ops[0][SW-1:0]);
    b_r = fold(ops[1][SW-1:0]);
    c_r = fold(ops[2][SW-1:0]);
    mac = 11'(a_r) * 11'(b_r) + 11'(c_r);
    red = mac % 11'd31;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NOPS; k++) begin
      unique case (tern[2*k +: 2])
        2'b01:   sum = sum + ops[k];
        2'b11:   sum = sum - ops[k];
        default: sum = sum;
      endcase
    end
  end

  assign res = mode ? sum : OPW'(red);
endmodule

// File: rtl/dla_ctrl.sv
module dla_ctrl
  import dla_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_mode,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_dst,
  input  logic [2*NOPS-1:0] cmd_tern,
  output dla_state_e        state,
  output logic [CW-1:0]     load_idx,
  output logic [AW-1:0]     load_addr,
  output logic              mode_q,
  output logic [2*NOPS-1:0] tern_q,
  output logic [AW-1:0]     dst_q
);
  dla_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] base_q;
  logic          cmd_en;
  logic [CW-1:0] last_idx;

  assign cmd_en   = (state_q == ST_IDLE) && start;
  assign last_idx = mode_q ? CW'(NOPS - 1) : CW'(2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LOAD;
        cnt_d   = '0;
      end
      ST_LOAD: begin
        if (cnt_q == last_idx) state_d = ST_EXEC;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_EXEC: state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      tern_q <= '0;
      base_q <= '0;
      dst_q  <= '0;
    end else if (cmd_en) begin
      mode_q <= cmd_mode;
      tern_q <= cmd_tern;
      base_q <= cmd_base;
      dst_q  <= cmd_dst;
    end
  end

  assign state     = state_q;
  assign load_idx  = cnt_q;
  assign load_addr = base_q + AW'(cnt_q);
endmodule

// File: rtl/dual_lane_array.sv
module dual_lane_array
  import dla_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [VW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [VW-1:0]     rd_data,
  input  logic              start,
  input  logic              cmd_mode,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_dst,
  input  logic [2*NOPS-1:0] cmd_tern,
  output logic              busy,
  output logic              done
);
  dla_state_e        state;
  logic [CW-1:0]     load_idx;
  logic [AW-1:0]     load_addr;
  logic              mode_q;
  logic [2*NOPS-1:0] tern_q;
  logic [AW-1:0]     dst_q;
  logic [VW-1:0]     load_data;
  logic [VW-1:0]     opnd_q [NOPS];
  logic [VW-1:0]     lane_res;
  logic [VW-1:0]     wb_data;
  logic              wb_en;
  logic              host_we;
  logic              rf_we;
  logic [AW-1:0]     rf_waddr;
  logic [VW-1:0]     rf_wdata;

  dla_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_mode  (cmd_mode),
    .cmd_base  (cmd_base),
    .cmd_dst   (cmd_dst),
    .cmd_tern  (cmd_tern),
    .state     (state),
    .load_idx  (load_idx),
    .load_addr (load_addr),
    .mode_q    (mode_q),
    .tern_q    (tern_q),
    .dst_q     (dst_q)
  );

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_WB);
  assign wb_en   = (state == ST_WB);
  assign host_we = wr_en && (state == ST_IDLE);
  assign rf_we   = wb_en || host_we;
  assign rf_waddr = wb_en ? dst_q   : wr_addr;
  assign rf_wdata = wb_en ? wb_data : wr_data;

  dla_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (load_addr),
    .rdata_a (load_data),
    .raddr_b (rd_addr),
    .rdata_b (rd_data)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    logic opnd_en;
    assign opnd_en = (state == ST_LOAD) && (load_idx == CW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       opnd_q[k] <= '0;
      else if (opnd_en) opnd_q[k] <= load_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [NOPS-1:0][OPW-1:0] lane_ops;
    for (genvar k = 0; k < NOPS; k++) begin : g_pick
      assign lane_ops[k] = opnd_q[k][i*OPW +: OPW];
    end
    dla_lane u_lane (
      .mode (mode_q),
      .ops  (lane_ops),
      .tern (tern_q),
      .res  (lane_res[i*OPW +: OPW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wb_data <= '0;
    else if (state == ST_EXEC)   wb_data <= lane_res;
  end
endmodule

// File: rtl/dla_checker.sv
module dla_checker
  import dla_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mode_q,
  input logic          wb_en,
  input logic [VW-1:0] wb_data,
  input logic          host_we
);
  logic lanes_small;
  always_comb begin
    lanes_small = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (wb_data[i*OPW +: OPW] >= OPW'(31)) lanes_small = 1'b0;
  end

  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_mode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
  p_mod31_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !mode_q) |-> lanes_small);
  p_host_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_we);
endmodule

bind dual_lane_array dla_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .mode_q  (mode_q),
  .wb_en   (wb_en),
  .wb_data (wb_data),
  .host_we (host_we)
);

// File: tb/tb_dual_lane_array.sv
`timescale 1ns/1ps
module tb_dual_lane_array;
  import dla_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [VW-1:0]     wr_data;
  logic [AW-1:0]     rd_addr;
  logic [VW-1:0]     rd_data;
  logic              start;
  logic              cmd_mode;
  logic [AW-1:0]     cmd_base;
  logic [AW-1:0]     cmd_dst;
  logic [2*NOPS-1:0] cmd_tern;
  logic              busy;
  logic              done;

  int errors = 0;
  int checks = 0;
  logic [VW-1:0] model [NREG];

  always #5 clk = ~clk;

  dual_lane_array dut (.*);

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] ref_op(input logic m, input int base, input logic [11:0] t);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      int v;
      if (!m) begin
        int a, b, c;
        a = model[base % NREG][i*OPW +: 5];       if (a == 31) a = 0;
        b = model[(base+1) % NREG][i*OPW +: 5];   if (b == 31) b = 0;
        c = model[(base+2) % NREG][i*OPW +: 5];   if (c == 31) c = 0;
        v = (a * b + c) % 31;
      end else begin
        v = 0;
        for (int k = 0; k < NOPS; k++) begin
          int x;
          x = int'(model[(base+k) % NREG][i*OPW +: OPW]);
          if (t[2*k +: 2] == 2'b01) v = v + x;
          else if (t[2*k +: 2] == 2'b11) v = v - x;
        end
        v = ((v % 2048) + 2048) % 2048;
      end
      r[i*OPW +: OPW] = OPW'(v);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pattern(input int seed);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*OPW +: OPW] = OPW'((seed * 977 + i * 131 + (i * i) * seed) % 2048);
    return r;
  endfunction

  task automatic host_write(input int a, input logic [VW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
    rd_addr = AW'(a);
    #1 check("R2 write/read", rd_data, d);
  endtask

  // interfere: raise start with other mode and a host write in busy cycle 2
  task automatic run_cmd(input logic m, input int base, input int dst,
                         input logic [11:0] t, input bit interfere, input string req);
    int n;
    logic [VW-1:0] exp;
    n = m ? 6 : 3;
    exp = ref_op(m, base, t);
    @(negedge clk);
    start = 1'b1; cmd_mode = m; cmd_base = AW'(base); cmd_dst = AW'(dst); cmd_tern = t;
    for (int c = 1; c <= n + 2; c++) begin
      @(negedge clk);
      start = 1'b0;
      wr_en = 1'b0;
      checks++;
      if (busy !== 1'b1 || done !== (c == n + 2)) begin
        errors++;
        $display("FAIL R5 cycle %0d busy=%b done=%b expected busy=1 done=%b", c, busy, done, c == n + 2);
      end
      if (interfere && c == 2) begin
        start = 1'b1; cmd_mode = ~m; cmd_base = AW'(base + 1); cmd_tern = ~t;
        wr_en = 1'b1; wr_addr = AW'((dst + 1) % NREG); wr_data = {VW{1'b1}};
      end
    end
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R5 end busy=%b done=%b expected 0 0", busy, done);
    end
    model[dst] = exp;
    rd_addr = AW'(dst);
    #1 check(req, rd_data, exp);
    if (interfere) begin
      rd_addr = AW'((dst + 1) % NREG);
      #1 check("R7 write while busy", rd_data, model[(dst + 1) % NREG]);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    start = 1'b0; cmd_mode = 1'b0; cmd_base = '0; cmd_dst = '0; cmd_tern = '0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1 busy=%b done=%b expected 0 0", busy, done);
    end
    for (int r = 0; r < NREG; r++) begin
      rd_addr = AW'(r);
      #1 check("R1 reset contents", rd_data, '0);
    end

    for (int r = 0; r < NREG; r++) host_write(r, pattern(r + 3));

    run_cmd(1'b0, 0, 7, 12'h000, 0, "R3 mod31 mac");
    // operand with all-ones low bits (31 treated as 0) and set upper bits
    host_write(1, {LANES{11'h7FF}});
    run_cmd(1'b0, 0, 5, 12'h000, 0, "R3 value 31 and upper bits");
    run_cmd(1'b1, 0, 6, 12'b01_01_01_01_01_01, 0, "R4 all add");
    run_cmd(1'b1, 1, 0, 12'b11_00_01_10_11_01, 0, "R4 mixed signs");
    run_cmd(1'b1, 2, 3, 12'b11_11_11_11_11_11, 0, "R4 all subtract");
    run_cmd(1'b1, 6, 4, 12'b01_11_01_11_01_11, 0, "R8 wrap mode1");
    run_cmd(1'b0, 7, 2, 12'h000, 0, "R8 wrap mode0");
    run_cmd(1'b0, 3, 1, 12'h000, 1, "R6 start ignored mode0");
    run_cmd(1'b1, 4, 0, 12'b01_01_11_11_00_01, 1, "R6 start ignored mode1");
    run_cmd(1'b0, 1, 6, 12'hFFF, 0, "R9 mode0 after mode1");
    run_cmd(1'b1, 0, 7, 12'b00_00_00_00_00_01, 0, "R9 mode1 after mode0");
    run_cmd(1'b1, 0, 7, 12'b00_00_00_00_00_00, 0, "R4 all zero codes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule